// File: doc/BRIEF.md
# DMA Controller Register Front End

This block is the register slave that sits in front of a sixteen-channel DMA controller. It decodes an 8 KB byte window on a simple strobe bus. Each access is one cycle, with a separate read strobe and write strobe and a 32-bit data word. The low part of the window holds the controller-wide registers: a run enable, a free scratch word, and an interrupt mask with a set port and a clear port. A status word reports which channels have a completion pending.

Starting at byte 0x1000, sixteen windows of 32 bytes each belong to the channels. An access that lands there is not served locally. The block forwards it to the per-channel logic as a read or write pulse, with the channel number, the offset inside the window and the write data. The word that the channel logic returns is captured as the read result.

The pending-completion vector lives here. Channel logic raises a bit with a one-cycle set pulse and drops it with a one-cycle clear pulse. Read data is registered and comes with a valid flag one cycle after the read strobe.

Top module: `dma_regfront`

## Requirements
- R1: After reset the enable, the scratch word, the mask and every pending flag are zero, and reads of all global offsets return 0.
- R2: A write to byte offset 0x000 loads bit 31 of the data into the enable and changes nothing else. A read of 0x000 returns the enable in bit 31 and zero elsewhere.
- R3: A read of offset 0x004 returns the pending vector in bits 15:0, where bit n is channel n, and zero above.
- R4: Offset 0x010 stores any written word and returns it unchanged on read.
- R5: A write to 0x020 ORs the data into the 32-bit mask. Reads of 0x020 and 0x024 both return the mask.
- R6: A write to 0x024 clears every mask bit that is 1 in the data and keeps the others.
- R7: An access to a byte address A with 0x1000 <= A < 0x1200 raises `ch_wr` or `ch_rd` in the same cycle. It carries `ch_idx` = (A-0x1000)/32, `ch_offs` = A mod 32, and the write data, and it alters no global register.
- R8: A read inside a channel window returns the `ch_rdata` value present in the cycle of the read strobe.
- R9: `done_set[n]` sets pending bit n and `done_clr[n]` clears it, both at the next edge. When both are asserted in the same cycle, the set wins.
- R10: A read of any offset that is neither a global register nor a channel window returns 0. A write to one changes no register and raises no channel strobe.
- R11: `rd_valid` is high in exactly the cycle after each cycle with `req_rd` high, and `rd_data` holds the result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wr | input | 1 | Write strobe, one cycle per access |
| req_rd | input | 1 | Read strobe, one cycle per access |
| req_addr | input | 13 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| ch_wr | output | 1 | Write pulse forwarded to channel logic |
| ch_rd | output | 1 | Read pulse forwarded to channel logic |
| ch_idx | output | 4 | Addressed channel |
| ch_offs | output | 5 | Byte offset inside the channel window |
| ch_wdata | output | 32 | Write data forwarded to channel logic |
| ch_rdata | input | 32 | Read data from channel logic |
| done_set | input | 16 | Per-channel completion set pulses |
| done_clr | input | 16 | Per-channel completion clear pulses |
| ctrl_enable | output | 1 | Controller run enable |
| irq_mask | output | 32 | Interrupt mask |
| pending | output | 16 | Pending completion vector |

## Verification
The hardest case to reach from the ports is the edge of the channel region. The bench accesses the first and the last word of the region. It also accesses 0x1200, the first byte past the region, and the top of the 8 KB window. At each of these it checks that channel strobes fire only inside the region, and that a write outside it leaves every global register intact. A second hard case is a set pulse and a clear pulse on the same channel in one cycle. The bench drives both and then reads the status word, so the set-wins rule is observed through the register interface.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned OFS_CMD     = 'h000;
  localparam int unsigned OFS_STAT    = 'h004;
  localparam int unsigned OFS_SCRATCH = 'h010;
  localparam int unsigned OFS_MSET    = 'h020;
  localparam int unsigned OFS_MCLR    = 'h024;
  localparam int unsigned EN_BIT      = 31;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CMD,
    SEL_STAT,
    SEL_SCR,
    SEL_MSET,
    SEL_MCLR,
    SEL_CHAN
  } sel_e;
endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode
  import dma_rf_pkg::*;
#(
  parameter int unsigned AW      = 13,
  parameter int unsigned NCH     = 16,
  parameter int unsigned WIN_B   = 32,
  parameter int unsigned CH_BASE = 'h1000
) (
  input  logic [AW-1:0]          addr,
  output sel_e                   sel,
  output logic [$clog2(NCH)-1:0] ch_idx,
  output logic [$clog2(WIN_B)-1:0] ch_offs
);
  localparam int unsigned IDX_W = $clog2(NCH);
  localparam int unsigned OFS_W = $clog2(WIN_B);
  localparam logic [AW-1:0] BASE_A = AW'(CH_BASE);
  localparam logic [AW-1:0] END_A  = AW'(CH_BASE + NCH * WIN_B);

  logic [AW-1:0] word_a;
  logic [AW-1:0] rel;

  assign word_a  = {addr[AW-1:2], 2'b00};
  assign rel     = addr - BASE_A;
  assign ch_idx  = rel[OFS_W +: IDX_W];
  assign ch_offs = rel[OFS_W-1:0];

  always_comb begin
    if (word_a >= BASE_A && word_a < END_A)  sel = SEL_CHAN;
    else if (word_a == AW'(OFS_CMD))         sel = SEL_CMD;
    else if (word_a == AW'(OFS_STAT))        sel = SEL_STAT;
    else if (word_a == AW'(OFS_SCRATCH))     sel = SEL_SCR;
    else if (word_a == AW'(OFS_MSET))        sel = SEL_MSET;
    else if (word_a == AW'(OFS_MCLR))        sel = SEL_MCLR;
    else                                     sel = SEL_NONE;
  end
endmodule

// File: rtl/dma_rf_globals.sv
module dma_rf_globals
  import dma_rf_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  sel_e          sel,
  input  logic [DW-1:0] wdata,
  output logic          enable,
  output logic [DW-1:0] scratch,
  output logic [DW-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      enable  <= 1'b0;
      scratch <= '0;
      mask    <= '0;
    end else if (wr) begin
      unique case (sel)
        SEL_CMD:  enable  <= wdata[EN_BIT];
        SEL_SCR:  scratch <= wdata;
        SEL_MSET: mask    <= mask | wdata;
        SEL_MCLR: mask    <= mask & ~wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dma_rf_pending.sv
module dma_rf_pending #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] flags
);
  for (genvar n = 0; n < NCH; n++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flags[n] <= 1'b0;
      else if (set_i[n]) flags[n] <= 1'b1;
      else if (clr_i[n]) flags[n] <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_regfront.sv
module dma_regfront
  import dma_rf_pkg::*;
#(
  parameter int unsigned AW      = 13,
  parameter int unsigned DW      = 32,
  parameter int unsigned NCH     = 16,
  parameter int unsigned WIN_B   = 32,
  parameter int unsigned CH_BASE = 'h1000,
  localparam int unsigned IDX_W  = $clog2(NCH),
  localparam int unsigned OFS_W  = $clog2(WIN_B)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_wr,
  input  logic             req_rd,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             ch_wr,
  output logic             ch_rd,
  output logic [IDX_W-1:0] ch_idx,
  output logic [OFS_W-1:0] ch_offs,
  output logic [DW-1:0]    ch_wdata,
  input  logic [DW-1:0]    ch_rdata,
  input  logic [NCH-1:0]   done_set,
  input  logic [NCH-1:0]   done_clr,
  output logic             ctrl_enable,
  output logic [DW-1:0]    irq_mask,
  output logic [NCH-1:0]   pending
);
  sel_e          sel;
  logic [DW-1:0] scratch;
  logic [DW-1:0] rd_mux;

  dma_rf_decode #(
    .AW(AW), .NCH(NCH), .WIN_B(WIN_B), .CH_BASE(CH_BASE)
  ) u_decode (
    .addr(req_addr), .sel(sel), .ch_idx(ch_idx), .ch_offs(ch_offs)
  );

  dma_rf_globals #(.DW(DW)) u_globals (
    .clk(clk), .rst(rst), .wr(req_wr), .sel(sel), .wdata(req_wdata),
    .enable(ctrl_enable), .scratch(scratch), .mask(irq_mask)
  );

  dma_rf_pending #(.NCH(NCH)) u_pending (
    .clk(clk), .rst(rst), .set_i(done_set), .clr_i(done_clr), .flags(pending)
  );

  assign ch_wr    = req_wr && (sel == SEL_CHAN);
  assign ch_rd    = req_rd && (sel == SEL_CHAN);
  assign ch_wdata = req_wdata;

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_CMD:            rd_mux[EN_BIT] = ctrl_enable;
      SEL_STAT:           rd_mux[NCH-1:0] = pending;
      SEL_SCR:            rd_mux = scratch;
      SEL_MSET, SEL_MCLR: rd_mux = irq_mask;
      SEL_CHAN:           rd_mux = ch_rdata;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_rd;
      if (req_rd) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/dma_regfront_chk.sv
module dma_regfront_chk #(
  parameter int unsigned AW  = 13,
  parameter int unsigned DW  = 32,
  parameter int unsigned NCH = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           req_wr,
  input logic           req_rd,
  input logic [AW-1:0]  req_addr,
  input logic [DW-1:0]  req_wdata,
  input logic           rd_valid,
  input logic           ch_wr,
  input logic           ch_rd,
  input logic           ctrl_enable,
  input logic [DW-1:0]  irq_mask,
  input logic [NCH-1:0] pending,
  input logic [NCH-1:0] done_set
);
  logic [AW-1:0] wa;
  assign wa = {req_addr[AW-1:2], 2'b00};

  p_valid_after_rd_r11: assert property (@(posedge clk) disable iff (rst)
    req_rd |=> rd_valid);
  p_valid_needs_rd_r11: assert property (@(posedge clk) disable iff (rst)
    !req_rd |=> !rd_valid);
  p_chwr_from_wr_r7: assert property (@(posedge clk) disable iff (rst)
    ch_wr |-> req_wr);
  p_chrd_from_rd_r7: assert property (@(posedge clk) disable iff (rst)
    ch_rd |-> req_rd);
  p_enable_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(req_wr && wa == AW'(0)) |=> $stable(ctrl_enable));
  p_mask_set_r5: assert property (@(posedge clk) disable iff (rst)
    (req_wr && wa == AW'('h20)) |=> ((irq_mask & $past(req_wdata)) == $past(req_wdata)));
  p_mask_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (req_wr && wa == AW'('h24)) |=> ((irq_mask & $past(req_wdata)) == '0));
  p_pend_set_r9: assert property (@(posedge clk) disable iff (rst)
    (done_set != '0) |=> ((pending & $past(done_set)) == $past(done_set)));
endmodule

bind dma_regfront dma_regfront_chk #(.AW(AW), .DW(DW), .NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .req_wr(req_wr), .req_rd(req_rd), .req_addr(req_addr),
  .req_wdata(req_wdata), .rd_valid(rd_valid), .ch_wr(ch_wr), .ch_rd(ch_rd),
  .ctrl_enable(ctrl_enable), .irq_mask(irq_mask), .pending(pending),
  .done_set(done_set)
);

// File: tb/dma_regfront_tb.sv
module dma_regfront_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_wr = 1'b0, req_rd = 1'b0;
  logic [12:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data, ch_wdata, ch_rdata, irq_mask;
  logic        rd_valid, ch_wr, ch_rd, ctrl_enable;
  logic [3:0]  ch_idx;
  logic [4:0]  ch_offs;
  logic [15:0] done_set = '0, done_clr = '0, pending;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #2 clk = ~clk;

  // channel model: word depends on index and local offset
  assign ch_rdata = 32'hA500_0000 | (32'(ch_idx) << 8) | 32'(ch_offs);

  dma_regfront u_dut (
    .clk(clk), .rst(rst), .req_wr(req_wr), .req_rd(req_rd), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .rd_valid(rd_valid), .ch_wr(ch_wr),
    .ch_rd(ch_rd), .ch_idx(ch_idx), .ch_offs(ch_offs), .ch_wdata(ch_wdata),
    .ch_rdata(ch_rdata), .done_set(done_set), .done_clr(done_clr),
    .ctrl_enable(ctrl_enable), .irq_mask(irq_mask), .pending(pending)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // monitor: pop expected read results as they appear
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check("R11 unexpected rd_valid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    req_wr = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_wr = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_rd = 1'b1; req_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    #1;
    check({tag, " ch_rd"}, 32'(ch_rd), 32'((a >= 13'h1000) && (a < 13'h1200)));
    @(negedge clk);
    req_rd = 1'b0;
  endtask

  // channel-window write with same-cycle forwarding checks
  task automatic chwr(input logic [12:0] a, input logic [31:0] d, input bit inside_win);
    @(negedge clk);
    req_wr = 1'b1; req_addr = a; req_wdata = d;
    #1;
    check("R7/R10 ch_wr", 32'(ch_wr), 32'(inside_win));
    if (inside_win) begin
      check("R7 ch_idx", 32'(ch_idx), 32'((a - 13'h1000) >> 5));
      check("R7 ch_offs", 32'(ch_offs), 32'(a[4:0]));
      check("R7 ch_wdata", ch_wdata, d);
    end
    @(negedge clk);
    req_wr = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] s, input logic [15:0] c);
    @(negedge clk);
    done_set = s; done_clr = c;
    @(negedge clk);
    done_set = '0; done_clr = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] sh_mask;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 enable", 32'(ctrl_enable), 0);
    check("R1 mask", irq_mask, 0);
    check("R1 pending", 32'(pending), 0);
    rd(13'h000, 0, "R1 cmd");
    rd(13'h004, 0, "R1 stat");
    rd(13'h010, 0, "R1 scratch");
    rd(13'h020, 0, "R1 mask");

    // R2 enable
    wr(13'h000, 32'h7FFF_FFFF);
    rd(13'h000, 32'h0, "R2 enable off");
    wr(13'h000, 32'h8000_0000);
    rd(13'h000, 32'h8000_0000, "R2 enable on");
    check("R2 port", 32'(ctrl_enable), 1);
    rd(13'h010, 0, "R2 no side effect");

    // R4 scratch
    wr(13'h010, 32'hDEAD_BEEF);
    rd(13'h010, 32'hDEAD_BEEF, "R4 scratch");
    wr(13'h010, 32'h0123_4567);
    rd(13'h010, 32'h0123_4567, "R4 scratch again");

    // R5 / R6 mask
    sh_mask = 0;
    wr(13'h020, 32'h0000_00F0); sh_mask |= 32'h0000_00F0;
    wr(13'h020, 32'h8000_0003); sh_mask |= 32'h8000_0003;
    rd(13'h020, sh_mask, "R5 mask set");
    rd(13'h024, sh_mask, "R5 mask via clr offset");
    wr(13'h024, 32'h8000_0030); sh_mask &= ~32'h8000_0030;
    rd(13'h020, sh_mask, "R6 mask clear");
    check("R6 port", irq_mask, sh_mask);

    // R9 / R3 pending
    pulse(16'h8001, 16'h0);
    rd(13'h004, 32'h0000_8001, "R3 status after set");
    pulse(16'h0, 16'h0001);
    rd(13'h004, 32'h0000_8000, "R9 clear");
    pulse(16'h0100, 16'h8100);
    rd(13'h004, 32'h0000_0100, "R9 set wins");
    check("R9 port", 32'(pending), 32'h0100);

    // R7 / R8 channel windows, edges of region
    chwr(13'h1000, 32'h1111_2222, 1'b1);
    chwr(13'h11FC, 32'h3333_4444, 1'b1);
    chwr(13'h1064, 32'h5555_6666, 1'b1);
    rd(13'h1000, 32'hA500_0000, "R8 ch0 off0");
    rd(13'h11FC, 32'hA500_0F1C, "R8 ch15 off1c");
    rd(13'h10A8, 32'hA500_0508, "R8 ch5 off8");
    rd(13'h010, 32'h0123_4567, "R7 scratch untouched");
    rd(13'h020, sh_mask, "R7 mask untouched");

    // R10 unmapped
    chwr(13'h1200, 32'hFFFF_FFFF, 1'b0);
    chwr(13'h0008, 32'hFFFF_FFFF, 1'b0);
    chwr(13'h1FFC, 32'hFFFF_FFFF, 1'b0);
    rd(13'h0008, 0, "R10 read 0x008");
    rd(13'h1200, 0, "R10 read 0x1200");
    rd(13'h1FFC, 0, "R10 read 0x1ffc");
    rd(13'h0FFC, 0, "R10 read 0x0ffc");
    rd(13'h010, 32'h0123_4567, "R10 scratch kept");
    rd(13'h020, sh_mask, "R10 mask kept");
    rd(13'h000, 32'h8000_0000, "R10 enable kept");

    // R11 read latency: strobe, then valid exactly the next cycle
    @(negedge clk);
    check("R11 idle valid", 32'(rd_valid), 0);

    repeat (3) @(negedge clk);
    check("R11 queue drained", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule